// File: doc/BRIEF.md
# Compare Unit with Condition-Vector Result

This block compares two operands in one pass and builds a 15-bit vector of outcomes: equality, the signed and unsigned orderings, zero and sign tests, a bitwise-overlap test and a constant-true bit. A single fused operation takes the place of a separate compare followed by a set-on-condition step. A 4-bit selector either returns the whole vector, zero-extended to the data width, or picks one outcome and returns it as a 0/1 value.

A width select chooses a 64-bit or a 32-bit compare. In 32-bit mode only the low half of each operand counts, and bit 31 acts as the sign. The result is registered. It appears one cycle after a valid input, together with a valid flag.

Top module: `cmp_vector_unit`

## Requirements
- R1: During and right after reset, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is high exactly in the cycle after a cycle with `op_valid` high. `res_data` changes only in that cycle and otherwise holds its last value.
- R3: With `pick` = 4'hF, `res_data[14:0]` is the condition vector and `res_data[63:15]` is zero.
- R4: With `pick` from 0 to 14, `res_data[0]` equals condition bit `pick` and `res_data[63:1]` is zero.
- R5: Bit 0 is set when the operands are equal and bit 1 when they differ. Exactly one of the two is set.
- R6: Bits 2, 3, 4 and 5 are the signed a<b, a<=b, a>b and a>=b.
- R7: Bits 6, 7, 8 and 9 are the unsigned a<b, a<=b, a>b and a>=b.
- R8: Bit 10 is set when a is zero, bit 11 when b is zero, bit 12 when a is negative (top bit of the compared width), and bit 13 when a AND b is nonzero.
- R9: Bit 14 is always 1.
- R10: With `wide` = 0, the upper 32 bits of both operands have no effect, and bit 31 is the sign bit for bits 2 to 5 and bit 12. With `wide` = 1, all 64 bits count and bit 63 is the sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operands and controls are valid this cycle |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| wide | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| pick | input | 4 | 0 to 14 returns one condition bit; 4'hF returns the whole vector |
| res_valid | output | 1 | Result is valid this cycle |
| res_data | output | 64 | Registered result |

## Verification
Single-bit extraction and the 32-bit narrowing can act in the same operation. This is the case that matters most: the bit that is picked must come from the narrowed compare and not from the full 64-bit one. The bench sets up this case with operands whose low halves give one answer and whose high halves give the opposite, for example equal low words with different high words, or bit 31 set while bit 63 is clear. It then extracts the equality, sign and ordering bits in 32-bit mode. Each extracted bit is checked against a reference model in the bench that sign- or zero-extends the low word by its own route.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int COND_N = 15;
  localparam int SEL_W  = 4;
  localparam logic [SEL_W-1:0] SEL_WHOLE = 4'hF;

  localparam int B_EQ  = 0;
  localparam int B_NE  = 1;
  localparam int B_SLT = 2;
  localparam int B_SLE = 3;
  localparam int B_SGT = 4;
  localparam int B_SGE = 5;
  localparam int B_ULT = 6;
  localparam int B_ULE = 7;
  localparam int B_UGT = 8;
  localparam int B_UGE = 9;
  localparam int B_AZ  = 10;
  localparam int B_BZ  = 11;
  localparam int B_AN  = 12;
  localparam int B_AND = 13;
  localparam int B_ONE = 14;

  typedef logic [COND_N-1:0] cond_vec_t;
endpackage

// File: rtl/cmp_operand_prep.sv
module cmp_operand_prep #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              wide,
  output logic [DATA_W-1:0] sx_val,
  output logic [DATA_W-1:0] zx_val
);
  localparam int PAD_W = DATA_W - NARROW_W;

  function automatic logic [DATA_W-1:0] sext_narrow(input logic [DATA_W-1:0] v);
    return {{PAD_W{v[NARROW_W-1]}}, v[NARROW_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] zext_narrow(input logic [DATA_W-1:0] v);
    return {{PAD_W{1'b0}}, v[NARROW_W-1:0]};
  endfunction

  always_comb begin
    sx_val = wide ? raw : sext_narrow(raw);
    zx_val = wide ? raw : zext_narrow(raw);
  end
endmodule

// File: rtl/cmp_cond_gen.sv
module cmp_cond_gen
  import cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] sa,
  input  logic [DATA_W-1:0] sb,
  input  logic [DATA_W-1:0] ua,
  input  logic [DATA_W-1:0] ub,
  output cond_vec_t         conds
);
  logic eq, slt, ult;

  function automatic logic signed_less(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  always_comb begin
    eq  = (ua == ub);
    slt = signed_less(sa, sb);
    ult = (ua < ub);
    conds        = '0;
    conds[B_EQ]  = eq;
    conds[B_NE]  = ~eq;
    conds[B_SLT] = slt;
    conds[B_SLE] = slt | eq;
    conds[B_SGT] = ~(slt | eq);
    conds[B_SGE] = ~slt;
    conds[B_ULT] = ult;
    conds[B_ULE] = ult | eq;
    conds[B_UGT] = ~(ult | eq);
    conds[B_UGE] = ~ult;
    conds[B_AZ]  = (ua == '0);
    conds[B_BZ]  = (ub == '0);
    conds[B_AN]  = sa[DATA_W-1];
    conds[B_AND] = |(ua & ub);
    conds[B_ONE] = 1'b1;
  end
endmodule

// File: rtl/cmp_extract.sv
module cmp_extract
  import cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  cond_vec_t         conds,
  input  logic [SEL_W-1:0]  pick,
  output logic [DATA_W-1:0] value
);
  always_comb begin
    value = '0;
    if (pick == SEL_WHOLE) value[COND_N-1:0] = conds;
    else                   value[0] = conds[pick];
  end
endmodule

// File: rtl/cmp_vector_unit.sv
module cmp_vector_unit
  import cmp_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              wide,
  input  logic [SEL_W-1:0]  pick,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  logic [DATA_W-1:0] raw_ops [2];
  logic [DATA_W-1:0] sx_ops  [2];
  logic [DATA_W-1:0] zx_ops  [2];
  cond_vec_t         cond_vec;
  logic [DATA_W-1:0] next_res;

  assign raw_ops[0] = opnd_a;
  assign raw_ops[1] = opnd_b;

  for (genvar g = 0; g < 2; g++) begin : g_prep
    cmp_operand_prep #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_prep (
      .raw(raw_ops[g]), .wide(wide), .sx_val(sx_ops[g]), .zx_val(zx_ops[g])
    );
  end

  cmp_cond_gen #(.DATA_W(DATA_W)) u_cond (
    .sa(sx_ops[0]), .sb(sx_ops[1]), .ua(zx_ops[0]), .ub(zx_ops[1]), .conds(cond_vec)
  );

  cmp_extract #(.DATA_W(DATA_W)) u_ext (
    .conds(cond_vec), .pick(pick), .value(next_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_data <= next_res;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(res_data)));
  assert_whole_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && pick == SEL_WHOLE) |=> (res_data[DATA_W-1:COND_N] == '0 && res_data[B_ONE]));
  assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && pick != SEL_WHOLE) |=> (res_data[DATA_W-1:1] == '0));
  assert_eq_ne_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $countones(cond_vec[B_NE:B_EQ]) == 1);
  assert_signed_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> ($countones({cond_vec[B_SLT], cond_vec[B_SGE]}) == 1 &&
                  $countones({cond_vec[B_SLE], cond_vec[B_SGT]}) == 1));
  assert_unsigned_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> ($countones({cond_vec[B_ULT], cond_vec[B_UGE]}) == 1 &&
                  (cond_vec[B_UGT] -> cond_vec[B_NE])));
  assert_zero_not_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_vec[B_AZ]) |-> (!cond_vec[B_AN] && !cond_vec[B_AND]));
endmodule

// File: tb/tb_cmp_vector_unit.sv
module tb_cmp_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        wide = 1'b1;
  logic [3:0]  pick = 4'hF;
  logic        res_valid;
  logic [63:0] res_data;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_vector_unit dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .wide(wide), .pick(pick), .res_valid(res_valid), .res_data(res_data));

  function automatic logic [14:0] ref_vec(logic [63:0] a, logic [63:0] b, logic w);
    longint sa, sb;
    longint unsigned ua, ub;
    logic [14:0] v;
    if (w) begin sa = longint'(a); sb = longint'(b); ua = a; ub = b; end
    else begin
      sa = longint'(int'(a[31:0])); sb = longint'(int'(b[31:0]));
      ua = longint'({32'd0, a[31:0]}); ub = longint'({32'd0, b[31:0]});
    end
    v[0] = ua == ub;   v[1] = ua != ub;
    v[2] = sa < sb;    v[3] = sa <= sb;  v[4] = sa > sb;  v[5] = sa >= sb;
    v[6] = ua < ub;    v[7] = ua <= ub;  v[8] = ua > ub;  v[9] = ua >= ub;
    v[10] = ua == 0;   v[11] = ub == 0;  v[12] = sa < 0;
    v[13] = (ua & ub) != 0;
    v[14] = 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] ref_res(logic [63:0] a, logic [63:0] b, logic w, logic [3:0] s);
    logic [14:0] v = ref_vec(a, b, w);
    if (s == 4'hF) return {49'd0, v};
    return {63'd0, v[s]};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [63:0] a, logic [63:0] b, logic w, logic [3:0] s);
    @(negedge clk);
    opnd_a = a; opnd_b = b; wide = w; pick = s; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(tag, {63'd0, res_valid}, 64'd1);
    check(tag, res_data, ref_res(a, b, w, s));
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 valid", {63'd0, res_valid}, 64'd0);
    check("R1 data", res_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after", res_data, 64'd0);

    run_op("R2", 64'd5, 64'd5, 1'b1, 4'hF);
    held = res_data;
    opnd_a = 64'hFF; pick = 4'd1;
    @(negedge clk);
    check("R2 idle valid", {63'd0, res_valid}, 64'd0);
    check("R2 hold", res_data, held);

    run_op("R3", 64'h1, 64'h2, 1'b1, 4'hF);
    run_op("R4", 64'h1, 64'h2, 1'b1, 4'd6);
    run_op("R5 eq", 64'h1234, 64'h1234, 1'b1, 4'd0);
    run_op("R5 ne", 64'h1234, 64'h1235, 1'b1, 4'd1);
    run_op("R6 slt", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 4'd2);
    run_op("R6 sgt", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 4'd4);
    run_op("R6 sle", 64'd7, 64'd7, 1'b1, 4'd3);
    run_op("R7 ult", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 4'd6);
    run_op("R7 ugt", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 4'd8);
    run_op("R7 uge", 64'd0, 64'd0, 1'b1, 4'd9);
    run_op("R8 az", 64'd0, 64'd9, 1'b1, 4'd10);
    run_op("R8 bz", 64'd3, 64'd0, 1'b1, 4'd11);
    run_op("R8 an", 64'h8000_0000_0000_0000, 64'd0, 1'b1, 4'd12);
    run_op("R8 and", 64'h0100_0000_0000_0000, 64'h0100_0000_0000_0001, 1'b1, 4'd13);
    run_op("R9", 64'd0, 64'd0, 1'b0, 4'd14);
    run_op("R10 eq", 64'hAAAA_0000_0000_0042, 64'h5555_0000_0000_0042, 1'b0, 4'd0);
    run_op("R10 sign", 64'h0000_0000_8000_0000, 64'd1, 1'b0, 4'd2);
    run_op("R10 neg", 64'h0000_0000_8000_0000, 64'd0, 1'b0, 4'd12);
    run_op("R10 wide", 64'h0000_0000_8000_0000, 64'd1, 1'b1, 4'd4);
    run_op("R10 and", 64'hF000_0000_0000_0000, 64'hF000_0000_0000_0000, 1'b0, 4'd13);
    run_op("R10 vec", 64'hFFFF_FFFF_0000_0003, 64'h0000_0001_FFFF_FFFF, 1'b0, 4'hF);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      logic [3:0] s;
      a = {$urandom, $urandom};
      b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
      if ($urandom_range(0, 5) == 0) b[31:0] = a[31:0];
      if ($urandom_range(0, 7) == 0) a = '0;
      s = ($urandom_range(0, 2) == 0) ? 4'hF : 4'($urandom_range(0, 14));
      run_op((s == 4'hF) ? "R3 rand" : "R4 rand", a, b, 1'($urandom_range(0, 1)), s);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule